// File: doc/BRIEF.md
# Multi-Codec Output Slot Request Synchronizer

This block decides, frame by frame, whether the outgoing audio slots carry fresh samples when one, two or three codecs share a serial link and split the output channels among themselves. Codec 0 plays the front pair. Codec 1 plays the surround pair. Codec 2 plays center and LFE. Each codec signals that it wants data with an active-low request flag, which arrives once per incoming frame.

The block keeps every request it has seen in a pending set. At each frame boundary it compares that set with the codecs the selected channel mode needs. If all of them have asked, one sample set is popped from every output FIFO the mode uses, in a single frame, and the matching slots are tagged valid. If any of them has not asked yet, nothing is sent and the pending requests stay. Because the codecs take samples only together, their internal FIFOs stay in lockstep.

Link serialization and sample rate conversion belong to neighbouring blocks.

Top module: `slot_req_sync`

## Requirements
- R1: After reset, `slot_valid_o`, `fifo_pop_o` and `underrun_o` are all zero and no request is pending.
- R2: Mode encoding on `ch_mode_i` is 2'b00 = two channels, 2'b01 = four, 2'b10 = six. In two-channel mode only codec 0 (bit 0 of `req_n_i`) is needed. Requests from codecs 1 and 2 never cause a send in this mode.
- R3: In four-channel mode a send happens only when codecs 0 and 1 have both requested. It gives `fifo_pop_o` = 3'b011 and `slot_valid_o` = 6'b001111. Slot bits are 2g and 2g+1 for group g.
- R4: In six-channel mode a send needs all three codecs. It gives `fifo_pop_o` = 3'b111 and `slot_valid_o` = 6'b111111.
- R5: A request is recorded when `req_n_i` bit g is 0 during a `req_strobe_i` cycle. It stays pending across frames until a send or an underrun takes place.
- R6: A send or an underrun clears every pending request. A following frame with no new request sends nothing.
- R7: If the needed requests are present but any needed FIFO is empty (`fifo_empty_i` bit g = 1), then no FIFO is popped, all slots are invalid, and `underrun_o` pulses for one cycle. An empty FIFO of a group the mode does not use has no effect.
- R8: A frame that begins without the full needed set sends nothing: all slots are invalid and there is no pop.
- R9: The outputs change only in the cycle after a `frame_start_i` cycle. `fifo_pop_o` and `underrun_o` are one-cycle pulses. `slot_valid_o` holds its value until the next frame start.
- R10: Mode 2'b11 behaves as two-channel mode.
- R11: A request strobed in the same cycle as `frame_start_i` counts toward that frame's decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ch_mode_i | input | 2 | Output channel configuration |
| frame_start_i | input | 1 | One-cycle strobe at each outgoing frame boundary |
| req_strobe_i | input | 1 | Qualifies `req_n_i` for one cycle |
| req_n_i | input | NUM_GROUPS | Per-codec slot request flags, active low |
| fifo_empty_i | input | NUM_GROUPS | Per-group output FIFO empty status |
| slot_valid_o | output | NUM_GROUPS*SLOTS_PER_GROUP | Valid tags for the frame's output slots |
| fifo_pop_o | output | NUM_GROUPS | One-cycle pop strobe per group FIFO |
| underrun_o | output | 1 | One-cycle pulse when a due send is starved |

## Verification
The properties assume that `frame_start_i` is never high in two consecutive cycles and that `ch_mode_i` stays still across a frame decision. The pulse and pairing checks depend on both. The stimulus starts each frame from a task that leaves at least two idle cycles afterwards. It changes the mode only between frames. Requests are strobed on their own or in the same cycle as a frame start, which covers both ways a request can reach the decision.

// File: rtl/slot_sync_pkg.sv
package slot_sync_pkg;

   typedef enum logic [1:0] {
      CH_TWO  = 2'b00,
      CH_FOUR = 2'b01,
      CH_SIX  = 2'b10,
      CH_RSVD = 2'b11
   } ch_mode_e;

   localparam int MAX_GROUPS = 3;

   // Codec groups needed by each channel configuration
   function automatic logic [MAX_GROUPS-1:0] mode_need(input ch_mode_e m);
      case (m)
         CH_FOUR: mode_need = 3'b011;
         CH_SIX:  mode_need = 3'b111;
         default: mode_need = 3'b001;
      endcase
   endfunction

endpackage

// File: rtl/slot_req_tracker.sv
module slot_req_tracker #(
   parameter int NUM_GROUPS = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_strobe,
   input  logic [NUM_GROUPS-1:0] req_n,
   input  logic                  consume,
   output logic [NUM_GROUPS-1:0] pend_eff
);

   logic [NUM_GROUPS-1:0] pend_q;
   logic [NUM_GROUPS-1:0] fresh;

   assign fresh    = req_strobe ? ~req_n : '0;
   assign pend_eff = pend_q | fresh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pend_q <= '0;
      else if (consume)
         pend_q <= '0;
      else
         pend_q <= pend_eff;
   end

endmodule

// File: rtl/slot_fire_ctrl.sv
module slot_fire_ctrl #(
   parameter int NUM_GROUPS = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  frame_start,
   input  logic [NUM_GROUPS-1:0] need,
   input  logic [NUM_GROUPS-1:0] pend_eff,
   input  logic [NUM_GROUPS-1:0] fifo_empty,
   output logic                  consume,
   output logic [NUM_GROUPS-1:0] grp_valid,
   output logic [NUM_GROUPS-1:0] pop,
   output logic                  underrun
);

   logic ready;
   logic starve;
   logic send_ok;

   assign ready   = ((pend_eff & need) == need);
   assign starve  = |(fifo_empty & need);
   assign consume = frame_start & ready;
   assign send_ok = consume & ~starve;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         grp_valid <= '0;
         pop       <= '0;
         underrun  <= 1'b0;
      end else if (frame_start) begin
         grp_valid <= send_ok ? need : '0;
         pop       <= send_ok ? need : '0;
         underrun  <= consume & starve;
      end else begin
         pop       <= '0;
         underrun  <= 1'b0;
      end
   end

endmodule

// File: rtl/slot_valid_map.sv
module slot_valid_map #(
   parameter int NUM_GROUPS      = 3,
   parameter int SLOTS_PER_GROUP = 2
) (
   input  logic [NUM_GROUPS-1:0]                 grp_valid,
   output logic [NUM_GROUPS*SLOTS_PER_GROUP-1:0] slot_valid
);

   for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
      for (genvar s = 0; s < SLOTS_PER_GROUP; s++) begin : g_slot
         assign slot_valid[g*SLOTS_PER_GROUP+s] = grp_valid[g];
      end
   end

endmodule

// File: rtl/slot_req_sync.sv
module slot_req_sync
   import slot_sync_pkg::*;
#(
   parameter int NUM_GROUPS      = 3,
   parameter int SLOTS_PER_GROUP = 2
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic [1:0]                            ch_mode_i,
   input  logic                                  frame_start_i,
   input  logic                                  req_strobe_i,
   input  logic [NUM_GROUPS-1:0]                 req_n_i,
   input  logic [NUM_GROUPS-1:0]                 fifo_empty_i,
   output logic [NUM_GROUPS*SLOTS_PER_GROUP-1:0] slot_valid_o,
   output logic [NUM_GROUPS-1:0]                 fifo_pop_o,
   output logic                                  underrun_o
);

   localparam int NUM_SLOTS = NUM_GROUPS * SLOTS_PER_GROUP;

   if (NUM_GROUPS < 1 || NUM_GROUPS > MAX_GROUPS) begin : g_bad_groups
      $error("slot_req_sync: NUM_GROUPS must be 1..%0d", MAX_GROUPS);
   end
   if (SLOTS_PER_GROUP < 1) begin : g_bad_slots
      $error("slot_req_sync: SLOTS_PER_GROUP must be at least 1");
   end

   logic [MAX_GROUPS-1:0] need_full;
   logic [NUM_GROUPS-1:0] need;
   logic [NUM_GROUPS-1:0] pend_eff;
   logic [NUM_GROUPS-1:0] grp_valid;
   logic                  consume;
   logic [NUM_SLOTS-1:0]  slot_valid;

   assign need_full = mode_need(ch_mode_e'(ch_mode_i));
   assign need      = need_full[NUM_GROUPS-1:0];

   slot_req_tracker #(.NUM_GROUPS(NUM_GROUPS)) u_track (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_strobe (req_strobe_i),
      .req_n      (req_n_i),
      .consume    (consume),
      .pend_eff   (pend_eff)
   );

   slot_fire_ctrl #(.NUM_GROUPS(NUM_GROUPS)) u_fire (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_start (frame_start_i),
      .need        (need),
      .pend_eff    (pend_eff),
      .fifo_empty  (fifo_empty_i),
      .consume     (consume),
      .grp_valid   (grp_valid),
      .pop         (fifo_pop_o),
      .underrun    (underrun_o)
   );

   slot_valid_map #(
      .NUM_GROUPS      (NUM_GROUPS),
      .SLOTS_PER_GROUP (SLOTS_PER_GROUP)
   ) u_map (
      .grp_valid  (grp_valid),
      .slot_valid (slot_valid)
   );

   assign slot_valid_o = slot_valid;

endmodule

// File: rtl/slot_req_sync_chk.sv
module slot_req_sync_chk
   import slot_sync_pkg::*;
#(
   parameter int NUM_GROUPS      = 3,
   parameter int SLOTS_PER_GROUP = 2
) (
   input logic                                  clk,
   input logic                                  rst_n,
   input logic [1:0]                            ch_mode_i,
   input logic                                  frame_start_i,
   input logic [NUM_GROUPS*SLOTS_PER_GROUP-1:0] slot_valid_o,
   input logic [NUM_GROUPS-1:0]                 fifo_pop_o,
   input logic                                  underrun_o
);

   logic [MAX_GROUPS-1:0]                 need_full;
   logic [NUM_GROUPS-1:0]                 need_chk;
   logic [NUM_GROUPS*SLOTS_PER_GROUP-1:0] pop_slots;

   assign need_full = mode_need(ch_mode_e'(ch_mode_i));
   assign need_chk  = need_full[NUM_GROUPS-1:0];

   always_comb begin
      for (int i = 0; i < NUM_GROUPS*SLOTS_PER_GROUP; i++)
         pop_slots[i] = fifo_pop_o[i / SLOTS_PER_GROUP];
   end

   // R9: pops and underruns appear only right after a frame start
   p_pop_after_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ((fifo_pop_o != '0) || underrun_o) |-> $past(frame_start_i));

   // R9: one-cycle pulses
   p_pop_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_pop_o != '0) |=> (fifo_pop_o == '0));

   // R9: slot tags hold between frames
   p_valid_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(frame_start_i) |-> $stable(slot_valid_o));

   // R7: a starved frame pops nothing
   p_underrun_no_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      underrun_o |-> (fifo_pop_o == '0) && (slot_valid_o == '0));

   // R3: all groups of the mode are popped together, never a subset
   p_pop_whole_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_pop_o != '0) |-> (fifo_pop_o == need_chk));

   // R8: slot tags after a frame decision follow the pops of that frame
   p_valid_tracks_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(frame_start_i) |-> (slot_valid_o == pop_slots));

endmodule

bind slot_req_sync slot_req_sync_chk #(
   .NUM_GROUPS      (NUM_GROUPS),
   .SLOTS_PER_GROUP (SLOTS_PER_GROUP)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .ch_mode_i     (ch_mode_i),
   .frame_start_i (frame_start_i),
   .slot_valid_o  (slot_valid_o),
   .fifo_pop_o    (fifo_pop_o),
   .underrun_o    (underrun_o)
);

// File: tb/sim_slot_req_sync.sv
module sim_slot_req_sync;

   typedef struct {
      logic [5:0] valid;
      logic [2:0] pop;
      logic       ur;
      string      tag;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] ch_mode = 2'b00;
   logic       frame_start = 1'b0;
   logic       req_strobe = 1'b0;
   logic [2:0] req_n = 3'b111;
   logic [2:0] fifo_empty = 3'b000;
   logic [5:0] slot_valid;
   logic [2:0] fifo_pop;
   logic       underrun;

   int   checks = 0;
   int   errors = 0;
   bit   mon_en = 1'b0;
   bit   done = 1'b0;
   exp_t expq[$];

   always #10 clk = ~clk;

   slot_req_sync u0 (
      .clk           (clk),
      .rst_n         (rst_n),
      .ch_mode_i     (ch_mode),
      .frame_start_i (frame_start),
      .req_strobe_i  (req_strobe),
      .req_n_i       (req_n),
      .fifo_empty_i  (fifo_empty),
      .slot_valid_o  (slot_valid),
      .fifo_pop_o    (fifo_pop),
      .underrun_o    (underrun)
   );

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic send_req(input logic [2:0] m);
      @(negedge clk);
      req_strobe = 1'b1;
      req_n      = ~m;
      @(negedge clk);
      req_strobe = 1'b0;
      req_n      = 3'b111;
   endtask

   // Driver: one frame boundary, optional same-cycle request
   task automatic frame(input logic [2:0] m, input logic [5:0] ev,
                        input logic [2:0] ep, input logic eu, input string tag);
      exp_t e;
      e.valid = ev; e.pop = ep; e.ur = eu; e.tag = tag;
      expq.push_back(e);
      @(negedge clk);
      frame_start = 1'b1;
      if (m != 3'b000) begin
         req_strobe = 1'b1;
         req_n      = ~m;
      end
      @(negedge clk);
      frame_start = 1'b0;
      req_strobe  = 1'b0;
      req_n       = 3'b111;
      repeat (2) @(negedge clk);
   endtask

   // Monitor
   initial begin
      logic       fs;
      logic [5:0] last_valid;
      last_valid = 6'b0;
      forever begin
         @(posedge clk);
         fs = frame_start;
         @(negedge clk);
         #1;
         if (mon_en) begin
            if (fs) begin
               if (expq.size() == 0) begin
                  check(1'b0, "R9", "unexpected frame", 0, 1);
               end else begin
                  exp_t e;
                  e = expq.pop_front();
                  check(slot_valid == e.valid, e.tag, "slot_valid", slot_valid, e.valid);
                  check(fifo_pop == e.pop, e.tag, "fifo_pop", fifo_pop, e.pop);
                  check(underrun == e.ur, e.tag, "underrun", underrun, e.ur);
               end
            end else begin
               check(fifo_pop == 3'b0 && underrun == 1'b0, "R9", "pulse outside frame",
                     {underrun, fifo_pop}, 0);
               check(slot_valid == last_valid, "R9", "slot_valid hold", slot_valid, last_valid);
            end
            last_valid = slot_valid;
         end
      end
   end

   // Watchdog
   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check(slot_valid == 6'b0, "R1", "reset slot_valid", slot_valid, 0);
      check(fifo_pop == 3'b0, "R1", "reset fifo_pop", fifo_pop, 0);
      check(underrun == 1'b0, "R1", "reset underrun", underrun, 0);
      rst_n = 1'b1;
      @(negedge clk);
      mon_en = 1'b1;

      // R1: nothing pending after reset
      frame(3'b000, 6'b000000, 3'b000, 1'b0, "R1");

      // R2: two-channel follows codec 0
      ch_mode = 2'b00;
      send_req(3'b001);
      frame(3'b000, 6'b000011, 3'b001, 1'b0, "R2");
      // R6: cleared after send
      frame(3'b000, 6'b000000, 3'b000, 1'b0, "R6");
      // R2: other codecs alone never send in two-channel mode
      send_req(3'b110);
      frame(3'b000, 6'b000000, 3'b000, 1'b0, "R2");
      send_req(3'b001);
      frame(3'b000, 6'b000011, 3'b001, 1'b0, "R2");

      // R8 then R5: four-channel, requests across frames
      ch_mode = 2'b01;
      send_req(3'b001);
      frame(3'b000, 6'b000000, 3'b000, 1'b0, "R8");
      send_req(3'b010);
      frame(3'b000, 6'b001111, 3'b011, 1'b0, "R5");

      // R3: both in one strobe
      send_req(3'b011);
      frame(3'b000, 6'b001111, 3'b011, 1'b0, "R3");

      // R4, R11: six-channel, request in the frame-start cycle
      ch_mode = 2'b10;
      frame(3'b111, 6'b111111, 3'b111, 1'b0, "R11");
      send_req(3'b101);
      frame(3'b000, 6'b000000, 3'b000, 1'b0, "R4");
      send_req(3'b010);
      frame(3'b000, 6'b111111, 3'b111, 1'b0, "R4");

      // R7: starved group
      fifo_empty = 3'b100;
      send_req(3'b111);
      frame(3'b000, 6'b000000, 3'b000, 1'b1, "R7");
      fifo_empty = 3'b000;
      frame(3'b000, 6'b000000, 3'b000, 1'b0, "R7");

      // R7: empty FIFO of an unused group is harmless
      ch_mode = 2'b01;
      fifo_empty = 3'b100;
      send_req(3'b011);
      frame(3'b000, 6'b001111, 3'b011, 1'b0, "R7");
      fifo_empty = 3'b000;

      // R10: reserved mode acts as two channels
      ch_mode = 2'b11;
      send_req(3'b001);
      frame(3'b000, 6'b000011, 3'b001, 1'b0, "R10");
      frame(3'b000, 6'b000000, 3'b000, 1'b0, "R6");

      repeat (3) @(negedge clk);
      check(expq.size() == 0, "R9", "frames left unchecked", expq.size(), 0);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule